// File: doc/BRIEF.md
# Asynchronous static RAM access controller

This block lets synchronous logic read and write an external asynchronous static RAM of 512K sixteen-bit words that has a select for each byte lane. The host side is a valid/ready request port that carries a direction bit, a word address, write data and a two-bit lane mask. The block converts each accepted request into a timed strobe sequence on the memory pins and reports completion with a single-cycle done pulse. For reads, the captured data is presented with that pulse.

The memory is selected only while an access is in progress. Selection uses a pair of chip selects, one active-low and one active-high, which are always driven opposite to each other. Every strobe is held for a number of clock cycles derived from the clock period and the memory's 55 ns access time. The shared data bus is handled as three separate signals: driven value, sampled value and driver enable. The block enables its own driver only around a write pulse. It samples the bus only during a read with output enable low. When a write follows a read, one idle cycle is inserted first so that the memory has time to release the bus.

Top module: `sram_bridge`

## Requirements
- R1: A write followed by a read of the same word address returns the written lanes; the word address appears on `mem_addr` for the whole time the chip is selected.
- R2: `mem_ce_n` and `mem_ce` are always opposite; the chip is selected (`mem_ce_n`=0, `mem_ce`=1) only while an access is in progress.
- R3: A write holds `mem_we_n` low for exactly HOLD consecutive cycles, and `mem_oe_n` stays high for the whole write.
- R4: During a write, `dq_oe` is high in the cycle before `mem_we_n` falls, in every cycle that `mem_we_n` is low, and in the cycle after it rises. `dq_out` does not change while `dq_oe` stays high.
- R5: A read holds `mem_oe_n` low for exactly HOLD cycles with `mem_we_n` high and `dq_oe` low.
- R6: Read data is taken from `dq_in` on the last cycle that `mem_oe_n` is low. Lanes whose mask bit is 0 read back as zero.
- R7: Mask bit 0 selects the low byte (bits 7:0), which is driven on `mem_lb_n`. Mask bit 1 selects the high byte (bits 15:8), which is driven on `mem_ub_n`. Both enables are active low and apply to reads and to writes.
- R8: A write whose previous non-empty access was a read is preceded by one extra cycle in which all strobes are inactive and `dq_oe` is low.
- R9: `req_ready` is high only when the block is idle. Latency is counted from the accepting clock edge to the cycle in which `rsp_done` is high: HOLD+1 cycles for a read, HOLD+3 for a write, and HOLD+4 for a write that needs the turnaround.
- R10: A request with mask 00 selects nothing and pulses `rsp_done` in the first cycle after acceptance.
- R11: After the synchronous active-high reset, and whenever the block is idle, `mem_ce_n`, `mem_we_n`, `mem_oe_n`, `mem_lb_n` and `mem_ub_n` are high, `mem_ce` is low and `dq_oe` is low.
- R12: HOLD is ceil(ACCESS_NS/CLK_NS), with a minimum of 1. With the defaults (10 ns clock, 55 ns access) HOLD is 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done after a read |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_ce_n | output | 1 | Active-low chip select |
| mem_ce | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_lb_n | output | 1 | Low byte enable, active low |
| mem_ub_n | output | 1 | High byte enable, active low |
| dq_out | output | 16 | Value driven onto the data bus |
| dq_oe | output | 1 | Data bus driver enable |
| dq_in | input | 16 | Value sampled from the data bus |

## Verification
The bench runs every lane mask, including the empty one, over 64 addresses whose upper bits vary, and checks each one against a memory model connected to the pins. That model returns a filler pattern on disabled lanes and on a bus nobody is driving. A design that sampled at the wrong time, or failed to zero the unselected lanes, would return that pattern instead of the stored data. The bench measures request latency for writes after writes, writes after reads, reads and empty requests. A missing turnaround cycle or a pulse one cycle short or long shows up as a latency or strobe-count error. A per-cycle pin monitor catches a driver left on during a read, write enable falling without data on the bus, and selects that are not complementary.

// File: rtl/sram_bridge.sv
module sram_bridge #(
  parameter int ADDR_W    = 19,
  parameter int CLK_NS    = 10,
  parameter int ACCESS_NS = 55
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_mask,
  output logic              rsp_done,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_ce,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [15:0]       dq_out,
  output logic              dq_oe,
  input  logic [15:0]       dq_in
);
  localparam int HOLD_RAW = (ACCESS_NS + CLK_NS - 1) / CLK_NS;
  localparam int HOLD     = (HOLD_RAW < 1) ? 1 : HOLD_RAW;
  localparam int CW       = $clog2(HOLD + 1);

  typedef enum logic [2:0] {S_IDLE, S_TURN, S_WSET, S_WPUL, S_WHLD, S_RACC} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [1:0]    mask_q;
  logic          rd_last;
  logic [15:0]   lane_keep;

  assign req_ready = (state == S_IDLE);
  assign lane_keep = {{8{mask_q[1]}}, {8{mask_q[0]}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      cnt       <= '0;
      mask_q    <= '0;
      rd_last   <= 1'b0;
      mem_addr  <= '0;
      mem_ce_n  <= 1'b1;
      mem_ce    <= 1'b0;
      mem_we_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_lb_n  <= 1'b1;
      mem_ub_n  <= 1'b1;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          mem_addr <= req_addr;
          dq_out   <= req_wdata;
          mask_q   <= req_mask;
          if (req_mask == 2'b00) begin
            rsp_done <= 1'b1;
          end else if (req_write) begin
            if (rd_last) begin
              state <= S_TURN;
            end else begin
              state    <= S_WSET;
              mem_ce_n <= 1'b0;
              mem_ce   <= 1'b1;
              mem_lb_n <= ~req_mask[0];
              mem_ub_n <= ~req_mask[1];
              dq_oe    <= 1'b1;
            end
          end else begin
            state    <= S_RACC;
            cnt      <= CW'(HOLD - 1);
            mem_ce_n <= 1'b0;
            mem_ce   <= 1'b1;
            mem_oe_n <= 1'b0;
            mem_lb_n <= ~req_mask[0];
            mem_ub_n <= ~req_mask[1];
          end
        end
        S_TURN: begin
          state    <= S_WSET;
          mem_ce_n <= 1'b0;
          mem_ce   <= 1'b1;
          mem_lb_n <= ~mask_q[0];
          mem_ub_n <= ~mask_q[1];
          dq_oe    <= 1'b1;
        end
        S_WSET: begin
          state    <= S_WPUL;
          cnt      <= CW'(HOLD - 1);
          mem_we_n <= 1'b0;
          rd_last  <= 1'b0;
        end
        S_WPUL: begin
          if (cnt == '0) begin
            state    <= S_WHLD;
            mem_we_n <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        S_WHLD: begin
          state    <= S_IDLE;
          mem_ce_n <= 1'b1;
          mem_ce   <= 1'b0;
          mem_lb_n <= 1'b1;
          mem_ub_n <= 1'b1;
          dq_oe    <= 1'b0;
          rsp_done <= 1'b1;
        end
        S_RACC: begin
          if (cnt == '0) begin
            state     <= S_IDLE;
            rsp_rdata <= dq_in & lane_keep;
            rsp_done  <= 1'b1;
            rd_last   <= 1'b1;
            mem_ce_n  <= 1'b1;
            mem_ce    <= 1'b0;
            mem_oe_n  <= 1'b1;
            mem_lb_n  <= 1'b1;
            mem_ub_n  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_bridge_chk.sv
module sram_bridge_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_mask,
  input logic              rsp_done,
  input logic              mem_ce_n,
  input logic              mem_ce,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_lb_n,
  input logic              mem_ub_n,
  input logic [15:0]       dq_out,
  input logic              dq_oe
);
  p_sel_pair_r2: assert property (@(posedge clk) disable iff (rst)
    mem_ce_n == ~mem_ce);
  p_we_has_data_r4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> dq_oe && mem_oe_n);
  p_data_steady_r4: assert property (@(posedge clk) disable iff (rst)
    dq_oe && $past(dq_oe) |-> $stable(dq_out));
  p_no_drive_on_read_r5: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !dq_oe && mem_we_n);
  p_turnaround_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(dq_oe) |-> $past(mem_oe_n, 2));
  p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> req_ready);
  p_empty_req_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_ready && req_mask == 2'b00 |=> rsp_done && mem_ce_n);
  p_idle_parked_r11: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> mem_ce_n && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !dq_oe);
endmodule

bind sram_bridge sram_bridge_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/tb_sram_bridge.sv
module tb_sram_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 19;
  localparam int HOLD = 6;  // R12: ceil(55/10)

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0] req_mask = '0;
  logic req_ready, rsp_done;
  logic [15:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, dq_oe;
  logic [15:0] dq_out, dq_in;

  always #(CLK_PERIOD/2) clk = ~clk;

  sram_bridge dut (.*);

  int checks = 0, fails = 0;
  logic [15:0] model [64];
  logic [15:0] shadow [64];
  logic sel;
  assign sel = !mem_ce_n && mem_ce;
  assign dq_in = (sel && !mem_oe_n && mem_we_n) ?
    {mem_ub_n ? 8'hA5 : model[mem_addr[5:0]][15:8], mem_lb_n ? 8'hA5 : model[mem_addr[5:0]][7:0]}
    : 16'h5A5A;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  int we_cnt, oe_cnt, sel_cnt;
  logic [AW-1:0] cur_addr;
  logic p_we_n = 1, p_oe = 0;
  logic [15:0] p_dout = '0;
  bit mon_on = 0;

  always @(negedge clk) if (mon_on) begin
    if (!mem_we_n) we_cnt++;
    if (!mem_oe_n) oe_cnt++;
    if (sel) sel_cnt++;
    chk(mem_ce_n == ~mem_ce, "R2 selects complementary", {mem_ce_n, mem_ce}, 2'b10);
    if (sel) chk(mem_addr == cur_addr, "R1 address on pins", mem_addr, cur_addr);
    if (!mem_oe_n) chk(!dq_oe && mem_we_n, "R5 driver off during read", {dq_oe, mem_we_n}, 2'b01);
    if (!mem_we_n) chk(dq_oe && mem_oe_n, "R4 data driven in write pulse", {dq_oe, mem_oe_n}, 2'b11);
    if (!mem_we_n && p_we_n) chk(p_oe, "R4 data before we falls", p_oe, 1);
    if (mem_we_n && !p_we_n) chk(dq_oe, "R4 data after we rises", dq_oe, 1);
    if (dq_oe && p_oe) chk(dq_out == p_dout, "R4 data stable", dq_out, p_dout);
    if (sel && !mem_we_n) begin
      if (!mem_lb_n) model[mem_addr[5:0]][7:0] = dq_out[7:0];
      if (!mem_ub_n) model[mem_addr[5:0]][15:8] = dq_out[15:8];
    end
    p_we_n = mem_we_n; p_oe = dq_oe; p_dout = dq_out;
  end

  bit prev_rd = 0;

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [15:0] d, input logic [1:0] m);
    int lat, exp_lat;
    logic [15:0] keep, exp_d;
    keep = {{8{m[1]}}, {8{m[0]}}};
    @(negedge clk);
    chk(req_ready, "R9 ready when idle", req_ready, 1);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    cur_addr = a; we_cnt = 0; oe_cnt = 0; sel_cnt = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!rsp_done && lat < 50) begin
      chk(!req_ready, "R9 not ready while busy", req_ready, 0);
      @(negedge clk); lat++;
    end
    if (m == 2'b00) begin
      exp_lat = 1;
      chk(lat == exp_lat, "R10 empty request latency", lat, exp_lat);
      chk(sel_cnt == 0 && we_cnt == 0 && oe_cnt == 0, "R10 no strobes", sel_cnt, 0);
    end else if (wr) begin
      exp_lat = prev_rd ? HOLD + 4 : HOLD + 3;
      chk(lat == exp_lat, prev_rd ? "R8 write after read latency" : "R9 write latency", lat, exp_lat);
      chk(we_cnt == HOLD, "R3 we low cycles", we_cnt, HOLD);
      chk(oe_cnt == 0, "R3 oe high in write", oe_cnt, 0);
      chk(sel_cnt == HOLD + 2, "R7 write select cycles", sel_cnt, HOLD + 2);
      shadow[a[5:0]] = (shadow[a[5:0]] & ~keep) | (d & keep);
      prev_rd = 0;
    end else begin
      exp_lat = HOLD + 1;
      chk(lat == exp_lat, "R9 read latency", lat, exp_lat);
      chk(oe_cnt == HOLD && we_cnt == 0, "R5 oe low cycles", oe_cnt, HOLD);
      exp_d = shadow[a[5:0]] & keep;
      chk(rsp_rdata == exp_d, "R6 R7 R1 read data", rsp_rdata, exp_d);
      prev_rd = 1;
    end
    @(negedge clk);
    chk(!rsp_done, "R9 done is one pulse", rsp_done, 0);
    chk(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !dq_oe,
        "R11 parked when idle", {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, dq_oe}, 7'b1011110);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin model[i] = '0; shadow[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_ce_n && !mem_ce && mem_we_n && mem_oe_n && mem_lb_n && mem_ub_n && !dq_oe && !rsp_done,
        "R11 reset state", {mem_ce_n, mem_ce, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n, dq_oe}, 7'b1011110);
    rst = 0;
    mon_on = 1;
    for (int k = 0; k < 64; k++)
      do_req(1, {13'(k * 37), 6'(k)}, 16'(k * 16'h1357 + 16'h0101), 2'b11);
    for (int k = 0; k < 64; k++) begin
      logic [AW-1:0] a;
      a = {13'(k * 91 + 5), 6'(k)};
      do_req(0, a, 16'h0, 2'(k));
      do_req(1, a, 16'(~(k * 16'h2468)), 2'(k + 1));
      do_req(1, a, 16'(k * 16'h0F0F), 2'(k + 2));
      do_req(0, a, 16'h0, 2'(k + 3));
      do_req(0, a, 16'h0, 2'b11);
    end
    finish_run();
  end
endmodule